// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the host-facing register file of a single-channel ATA disk interface. A host reads and writes eight byte-wide registers at consecutive offsets, plus one alternate register that reads as a second copy of the status byte and takes device-control writes. The block holds the addressing registers and packs the drive/head select byte. It composes the status byte from the presence of the selected drive, the state of the data path and the error register. It keeps a level interrupt request and decodes each byte written to the command register.

The sector data path, the medium and packet-command transport live in neighbouring blocks. This block passes data-port accesses through to them as strobes. It issues one-cycle start strobes for read, write, identify and packet commands, and takes a completion pulse back, which raises the interrupt. Commands that need no data movement complete at once. Commands that cannot be honoured are aborted through the error register.

Top module: `ata_tf_top`

## Requirements
- R1: With `altSel` low, host writes at offsets 2 (sector count), 3 (sector), 4 (cylinder low) and 5 (cylinder high) store the byte, and reads at the same offsets return it. All four registers reset to 0x00.
- R2: Offset 6 holds the select byte: bits 7:6 sector-size code, bit 5 LBA flag, bit 4 drive number, bits 3:0 head. A read returns the written byte unchanged. Bit 4 chooses which bit of `drivePresent` and `drivePacket` applies.
- R3: The status byte (read at offset 7) has bit 6 (ready) and bit 4 (seek done) set when the selected drive is present. It has bit 3 (data request) set when `bufNonEmpty` or `writeBusy` is high, and bit 0 (error) set when the error register is nonzero. All other bits read 0.
- R4: A status read at offset 7 clears `irq` at the clock edge that ends the read. A read with `altSel` high returns the same status byte and leaves `irq` unchanged.
- R5: A read at offset 1 returns the error register, and the register is 0x00 from the next cycle on.
- R6: A write with `altSel` high and bit 2 set enters the soft-reset state, which lasts until the next command write. In that state, when the selected drive is a packet device, offset 4 reads 0x14 and offset 5 reads 0xEB. Otherwise they read their stored values.
- R7: A command sent to an absent drive, or code 0xEC sent to a packet drive, sets the abort bit (bit 2, value 0x04) in the error register. It raises `irq` and produces no start strobe.
- R8: Command 0xEF with feature byte (offset 1 write) 0x03 completes without error. With any other feature byte it sets abort. Both cases raise `irq`.
- R9: Security commands 0xF1 to 0xF6, and any code not listed in R8, R11 or R13, set abort without raising `irq`.
- R10: Every command write first clears the error register, so the error register afterwards holds only that command's result.
- R11: Codes 0x20/0xC4 pulse `readStart` and codes 0x30/0xC5 pulse `writeStart` during the write cycle, without raising `irq`. A `cmdDone` pulse sets `irq`, which stays high until a status read.
- R12: After reset `irq` is 0 and the error register reads 0x00.
- R13: Codes 0x10, 0x91, 0xE1, 0xC6 and 0x08 raise `irq` with no error. Code 0xEC to a non-packet drive, and code 0xA1, pulse `identStart` and raise `irq`. Code 0x90 raises `irq` and sets the error register to 0x01. Code 0xA0 pulses `packetStart` without raising `irq`.
- R14: Offset 0 is the data port: a read returns `dataIn` and asserts `dataRdStb` in that cycle, and a write asserts `dataWrStb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Register offset |
| altSel | input | 1 | Selects the alternate status / device-control register |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Read byte, valid in the cycle of `hostRd` |
| dataIn | input | 8 | Byte from the sector buffer for data-port reads |
| dataRdStb | output | 1 | Data-port read strobe |
| dataWrStb | output | 1 | Data-port write strobe |
| drivePresent | input | 2 | Per-drive presence |
| drivePacket | input | 2 | Per-drive packet-device flag |
| bufNonEmpty | input | 1 | Sector buffer holds unread data |
| writeBusy | input | 1 | A write transfer still expects data |
| cmdDone | input | 1 | Completion pulse from the data path |
| irq | output | 1 | Interrupt request level |
| readStart | output | 1 | Read command start strobe |
| writeStart | output | 1 | Write command start strobe |
| identStart | output | 1 | Identify command start strobe |
| packetStart | output | 1 | Packet command start strobe |
| cmdCode | output | 8 | Last command byte written |

## Verification
The command decoder is driven with every class of code: data-moving reads and writes, identify on disk and on packet drives, set-features with a good and a bad feature byte, immediate no-data commands, diagnose, packet, security and an unlisted code. Each case is also tried against an absent drive. The strobes, `irq` and the error byte tell apart the path a code took. Status is read with the drive present and absent, and with each data-request source, which separates the bit sources. Status reads and alternate reads are interleaved with pending interrupts to tell a clearing read from a non-clearing one. Cylinder reads are repeated inside and outside the soft-reset state on packet and non-packet drives, to separate the signature from the stored values.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DATA   = 3'd0,
    OFF_ERR    = 3'd1,
    OFF_COUNT  = 3'd2,
    OFF_SECTOR = 3'd3,
    OFF_CYLLO  = 3'd4,
    OFF_CYLHI  = 3'd5,
    OFF_SELECT = 3'd6,
    OFF_CMD    = 3'd7
  } tfOffset_t;

  // status bit positions
  localparam int ST_ERR  = 0;
  localparam int ST_DRQ  = 3;
  localparam int ST_DSC  = 4;
  localparam int ST_DRDY = 6;

  // error register values
  localparam logic [REG_W-1:0] ERR_ABORT = 8'h04;
  localparam logic [REG_W-1:0] ERR_DIAG  = 8'h01;

  // device-control soft reset bit
  localparam int CTL_SRST = 2;

  // reset signature of a packet device
  localparam logic [REG_W-1:0] SIG_LO = 8'h14;
  localparam logic [REG_W-1:0] SIG_HI = 8'hEB;

  // command codes
  localparam logic [REG_W-1:0] CMD_READ         = 8'h20;
  localparam logic [REG_W-1:0] CMD_READ_MULTI   = 8'hC4;
  localparam logic [REG_W-1:0] CMD_WRITE        = 8'h30;
  localparam logic [REG_W-1:0] CMD_WRITE_MULTI  = 8'hC5;
  localparam logic [REG_W-1:0] CMD_IDENTIFY     = 8'hEC;
  localparam logic [REG_W-1:0] CMD_PKT_IDENTIFY = 8'hA1;
  localparam logic [REG_W-1:0] CMD_PACKET       = 8'hA0;
  localparam logic [REG_W-1:0] CMD_SET_FEATURES = 8'hEF;
  localparam logic [REG_W-1:0] CMD_RECAL        = 8'h10;
  localparam logic [REG_W-1:0] CMD_INIT_PARAMS  = 8'h91;
  localparam logic [REG_W-1:0] CMD_IDLE_NOW     = 8'hE1;
  localparam logic [REG_W-1:0] CMD_SET_MULTI    = 8'hC6;
  localparam logic [REG_W-1:0] CMD_DEV_RESET    = 8'h08;
  localparam logic [REG_W-1:0] CMD_DIAG         = 8'h90;
  localparam logic [REG_W-1:0] CMD_SEC_LO       = 8'hF1;
  localparam logic [REG_W-1:0] CMD_SEC_HI       = 8'hF6;

  localparam logic [REG_W-1:0] FEAT_XFER_MODE = 8'h03;

  typedef struct packed {
    logic [1:0] secSize;
    logic       lba;
    logic       drv;
    logic [3:0] head;
  } selReg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             wrFeat;
    logic             wrCount;
    logic             wrSector;
    logic             wrCylLo;
    logic             wrCylHi;
    logic             wrSelect;
    logic             wrCmd;
    logic             rdErr;
    logic [REG_W-1:0] cmdErr;
  } tfStrobes_t;

endpackage

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              altSel,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [REG_W-1:0]  hostWdata,
  input  logic              selPresent,
  input  logic              selPacket,
  input  logic [REG_W-1:0]  featVal,
  input  logic              cmdDone,
  output tfStrobes_t        strb,
  output logic              irq,
  output logic              resetState,
  output logic              readStart,
  output logic              writeStart,
  output logic              identStart,
  output logic              packetStart,
  output logic              dataRdStb,
  output logic              dataWrStb
);

  logic tfRd, tfWr, cmdWr, statusRd, ctlWr;
  logic abortCmd, raiseNow, diagCmd;
  logic rdGo, wrGo, idGo, pkGo;

  assign tfRd     = hostRd && !altSel;
  assign tfWr     = hostWr && !altSel;
  assign cmdWr    = tfWr && (hostAddr == OFF_CMD);
  assign statusRd = tfRd && (hostAddr == OFF_CMD);
  assign ctlWr    = hostWr && altSel;

  // command decode, evaluated on the byte being written
  always_comb begin
    abortCmd = 1'b0;
    raiseNow = 1'b0;
    diagCmd  = 1'b0;
    rdGo     = 1'b0;
    wrGo     = 1'b0;
    idGo     = 1'b0;
    pkGo     = 1'b0;
    if (!selPresent) begin
      abortCmd = 1'b1;
      raiseNow = 1'b1;
    end else begin
      case (hostWdata)
        CMD_READ, CMD_READ_MULTI:   rdGo = 1'b1;
        CMD_WRITE, CMD_WRITE_MULTI: wrGo = 1'b1;
        CMD_IDENTIFY: begin
          raiseNow = 1'b1;
          if (selPacket) abortCmd = 1'b1;
          else           idGo     = 1'b1;
        end
        CMD_PKT_IDENTIFY: begin
          raiseNow = 1'b1;
          idGo     = 1'b1;
        end
        CMD_SET_FEATURES: begin
          raiseNow = 1'b1;
          abortCmd = (featVal != FEAT_XFER_MODE);
        end
        CMD_RECAL, CMD_INIT_PARAMS, CMD_IDLE_NOW,
        CMD_SET_MULTI, CMD_DEV_RESET:
          raiseNow = 1'b1;
        CMD_DIAG: begin
          raiseNow = 1'b1;
          diagCmd  = 1'b1;
        end
        CMD_PACKET: pkGo = 1'b1;
        default: begin
          // security class and unlisted codes: silent abort
          abortCmd = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrFeat   = tfWr && (hostAddr == OFF_ERR);
    strb.wrCount  = tfWr && (hostAddr == OFF_COUNT);
    strb.wrSector = tfWr && (hostAddr == OFF_SECTOR);
    strb.wrCylLo  = tfWr && (hostAddr == OFF_CYLLO);
    strb.wrCylHi  = tfWr && (hostAddr == OFF_CYLHI);
    strb.wrSelect = tfWr && (hostAddr == OFF_SELECT);
    strb.wrCmd    = cmdWr;
    strb.rdErr    = tfRd && (hostAddr == OFF_ERR);
    strb.cmdErr   = (abortCmd ? ERR_ABORT : '0) | (diagCmd ? ERR_DIAG : '0);
  end

  assign readStart   = cmdWr && rdGo;
  assign writeStart  = cmdWr && wrGo;
  assign identStart  = cmdWr && idGo;
  assign packetStart = cmdWr && pkGo;
  assign dataRdStb   = tfRd && (hostAddr == OFF_DATA);
  assign dataWrStb   = tfWr && (hostAddr == OFF_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if ((cmdWr && raiseNow) || cmdDone) begin
      irq <= 1'b1;
    end else if (statusRd) begin
      irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetState <= 1'b0;
    end else if (ctlWr && hostWdata[CTL_SRST]) begin
      resetState <= 1'b1;
    end else if (cmdWr) begin
      resetState <= 1'b0;
    end
  end

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tfStrobes_t        strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              altSel,
  input  logic [REG_W-1:0]  hostWdata,
  input  logic [REG_W-1:0]  dataIn,
  input  logic              selPresent,
  input  logic              selPacket,
  input  logic              bufNonEmpty,
  input  logic              writeBusy,
  input  logic              resetState,
  output logic              selDrv,
  output logic [REG_W-1:0]  featVal,
  output logic [REG_W-1:0]  errVal,
  output logic [REG_W-1:0]  cmdCode,
  output logic [REG_W-1:0]  hostRdata
);

  logic [REG_W-1:0] countReg, sectorReg, cylLoReg, cylHiReg;
  selReg_t          selReg;
  logic [REG_W-1:0] statusByte;
  logic             showSig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featVal   <= '0;
      countReg  <= '0;
      sectorReg <= '0;
      cylLoReg  <= '0;
      cylHiReg  <= '0;
      selReg    <= '0;
      cmdCode   <= '0;
    end else begin
      if (strb.wrFeat)   featVal   <= hostWdata;
      if (strb.wrCount)  countReg  <= hostWdata;
      if (strb.wrSector) sectorReg <= hostWdata;
      if (strb.wrCylLo)  cylLoReg  <= hostWdata;
      if (strb.wrCylHi)  cylHiReg  <= hostWdata;
      if (strb.wrSelect) selReg    <= selReg_t'(hostWdata);
      if (strb.wrCmd)    cmdCode   <= hostWdata;
    end
  end

  // error register: a command replaces it, an error read empties it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errVal <= '0;
    end else if (strb.wrCmd) begin
      errVal <= strb.cmdErr;
    end else if (strb.rdErr) begin
      errVal <= '0;
    end
  end

  assign selDrv = selReg.drv;

  always_comb begin
    statusByte          = '0;
    statusByte[ST_DRDY] = selPresent;
    statusByte[ST_DSC]  = selPresent;
    statusByte[ST_DRQ]  = bufNonEmpty || writeBusy;
    statusByte[ST_ERR]  = (errVal != '0);
  end

  assign showSig = resetState && selPacket;

  always_comb begin
    if (altSel) begin
      hostRdata = statusByte;
    end else begin
      case (hostAddr)
        OFF_DATA:   hostRdata = dataIn;
        OFF_ERR:    hostRdata = errVal;
        OFF_COUNT:  hostRdata = countReg;
        OFF_SECTOR: hostRdata = sectorReg;
        OFF_CYLLO:  hostRdata = showSig ? SIG_LO : cylLoReg;
        OFF_CYLHI:  hostRdata = showSig ? SIG_HI : cylHiReg;
        OFF_SELECT: hostRdata = selReg;
        default:    hostRdata = statusByte;
      endcase
    end
  end

endmodule

// File: rtl/ata_tf_top.sv
module ata_tf_top
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              altSel,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [REG_W-1:0]  hostWdata,
  output logic [REG_W-1:0]  hostRdata,
  input  logic [REG_W-1:0]  dataIn,
  output logic              dataRdStb,
  output logic              dataWrStb,
  input  logic [1:0]        drivePresent,
  input  logic [1:0]        drivePacket,
  input  logic              bufNonEmpty,
  input  logic              writeBusy,
  input  logic              cmdDone,
  output logic              irq,
  output logic              readStart,
  output logic              writeStart,
  output logic              identStart,
  output logic              packetStart,
  output logic [REG_W-1:0]  cmdCode
);

  tfStrobes_t       strb;
  logic             selDrv, selPresent, selPacket, resetState;
  logic [REG_W-1:0] featVal, errVal;

  assign selPresent = drivePresent[selDrv];
  assign selPacket  = drivePacket[selDrv];

  ata_tf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .altSel(altSel),
    .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata),
    .selPresent(selPresent), .selPacket(selPacket), .featVal(featVal),
    .cmdDone(cmdDone), .strb(strb), .irq(irq), .resetState(resetState),
    .readStart(readStart), .writeStart(writeStart),
    .identStart(identStart), .packetStart(packetStart),
    .dataRdStb(dataRdStb), .dataWrStb(dataWrStb)
  );

  ata_tf_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr),
    .altSel(altSel), .hostWdata(hostWdata), .dataIn(dataIn),
    .selPresent(selPresent), .selPacket(selPacket),
    .bufNonEmpty(bufNonEmpty), .writeBusy(writeBusy),
    .resetState(resetState), .selDrv(selDrv), .featVal(featVal),
    .errVal(errVal), .cmdCode(cmdCode), .hostRdata(hostRdata)
  );

endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker
  import ata_tf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              altSel,
  input logic              hostRd,
  input logic              hostWr,
  input logic [REG_W-1:0]  hostWdata,
  input logic [1:0]        drivePresent,
  input logic              selDrv,
  input logic              cmdDone,
  input logic              irq,
  input logic              readStart,
  input logic              writeStart,
  input logic              identStart,
  input logic              packetStart,
  input logic [REG_W-1:0]  errVal
);

  logic cmdWrite;
  assign cmdWrite = hostWr && !altSel && (hostAddr == OFF_CMD);

  a_r4_status_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr && !altSel && hostAddr == OFF_CMD && !cmdDone) |=> !irq);

  a_r4_alt_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr && altSel && !cmdDone) |=> $stable(irq));

  a_r5_error_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr && !altSel && hostAddr == OFF_ERR) |=> (errVal == '0));

  a_r7_absent_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !drivePresent[selDrv]) |=> (irq && errVal == ERR_ABORT));

  a_r9_security_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && drivePresent[selDrv] && hostWdata >= CMD_SEC_LO &&
     hostWdata <= CMD_SEC_HI && !irq && !cmdDone) |=> (!irq && errVal == ERR_ABORT));

  a_r11_one_start: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({readStart, writeStart, identStart, packetStart}));

  a_r11_done_raises: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> irq);

endmodule

bind ata_tf_top ata_tf_checker u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .altSel(altSel),
  .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata),
  .drivePresent(drivePresent), .selDrv(selDrv), .cmdDone(cmdDone),
  .irq(irq), .readStart(readStart), .writeStart(writeStart),
  .identStart(identStart), .packetStart(packetStart), .errVal(errVal)
);

// File: tb/ata_tf_top_bench.sv
module ata_tf_top_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic       altSel = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata, dataIn = '0, cmdCode;
  logic       dataRdStb, dataWrStb;
  logic [1:0] drivePresent = 2'b01, drivePacket = 2'b00;
  logic       bufNonEmpty = 1'b0, writeBusy = 1'b0, cmdDone = 1'b0;
  logic       irq, readStart, writeStart, identStart, packetStart;

  int nChecks = 0;
  int nErrors = 0;
  logic [3:0] strbSeen;   // {read, write, ident, packet} during last write
  logic       rdStbSeen, wrStbSeen;

  always #2 clk = ~clk;

  ata_tf_top u_ata_tf_top (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic alt, input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    altSel = alt; hostAddr = a; hostRd = 1'b1;
    #1 v = hostRdata; rdStbSeen = dataRdStb;
    @(posedge clk);
    #1 hostRd = 1'b0; altSel = 1'b0;
  endtask

  task automatic wr(input logic alt, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    altSel = alt; hostAddr = a; hostWdata = d; hostWr = 1'b1;
    #1 strbSeen = {readStart, writeStart, identStart, packetStart};
    wrStbSeen = dataWrStb;
    @(posedge clk);
    #1 hostWr = 1'b0; altSel = 1'b0;
  endtask

  task automatic clearIrq();
    logic [7:0] v;
    rd(1'b0, 3'd7, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R12 irq after reset", {7'd0, irq}, 8'h00);
    rd(1'b0, 3'd1, v); check("R12 error after reset", v, 8'h00);
    rd(1'b0, 3'd2, v); check("R1 count reset", v, 8'h00);
    rd(1'b0, 3'd7, v); check("R3 status drive0 present", v, 8'h50);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(1'b0, 3'd2, 8'h11); wr(1'b0, 3'd3, 8'h22);
    wr(1'b0, 3'd4, 8'h33); wr(1'b0, 3'd5, 8'h44);
    rd(1'b0, 3'd2, v); check("R1 count", v, 8'h11);
    rd(1'b0, 3'd3, v); check("R1 sector", v, 8'h22);
    rd(1'b0, 3'd4, v); check("R1 cyl lo", v, 8'h33);
    rd(1'b0, 3'd5, v); check("R1 cyl hi", v, 8'h44);
    wr(1'b0, 3'd6, 8'hB5);
    rd(1'b0, 3'd6, v); check("R2 select readback", v, 8'hB5);
    rd(1'b0, 3'd7, v); check("R2 drive1 absent status", v, 8'h00);
    wr(1'b0, 3'd6, 8'hA0);
    rd(1'b0, 3'd7, v); check("R2 drive0 status", v, 8'h50);
  endtask

  task automatic t_status();
    logic [7:0] v;
    bufNonEmpty = 1'b1;
    rd(1'b0, 3'd7, v); check("R3 drq from buffer", v, 8'h58);
    bufNonEmpty = 1'b0; writeBusy = 1'b1;
    rd(1'b0, 3'd7, v); check("R3 drq from write", v, 8'h58);
    writeBusy = 1'b0;
  endtask

  task automatic t_data();
    logic [7:0] v;
    dataIn = 8'h3C;
    rd(1'b0, 3'd0, v); check("R14 data read", v, 8'h3C);
    check("R14 read strobe", {7'd0, rdStbSeen}, 8'h01);
    wr(1'b0, 3'd0, 8'h99); check("R14 write strobe", {7'd0, wrStbSeen}, 8'h01);
  endtask

  task automatic t_absent();
    logic [7:0] v;
    wr(1'b0, 3'd6, 8'hB0);             // drive1, absent
    wr(1'b0, 3'd7, 8'h20);
    check("R7 no strobe on absent", {4'd0, strbSeen}, 8'h00);
    check("R7 irq on absent", {7'd0, irq}, 8'h01);
    rd(1'b1, 3'd0, v); check("R4 alt status", v, 8'h01);
    check("R4 alt keeps irq", {7'd0, irq}, 8'h01);
    rd(1'b0, 3'd7, v); check("R3 status err bit", v, 8'h01);
    check("R4 status read clears irq", {7'd0, irq}, 8'h00);
    rd(1'b0, 3'd1, v); check("R7 abort code", v, 8'h04);
    rd(1'b0, 3'd1, v); check("R5 error cleared by read", v, 8'h00);
    wr(1'b0, 3'd6, 8'hA0);
  endtask

  task automatic t_identify();
    logic [7:0] v;
    drivePacket = 2'b01;
    wr(1'b0, 3'd7, 8'hEC);
    check("R7 identify on packet no strobe", {4'd0, strbSeen}, 8'h00);
    check("R7 identify on packet irq", {7'd0, irq}, 8'h01);
    rd(1'b0, 3'd1, v); check("R7 identify on packet abort", v, 8'h04);
    clearIrq();
    wr(1'b0, 3'd7, 8'hA1);
    check("R13 packet identify strobe", {4'd0, strbSeen}, 8'h02);
    check("R13 packet identify irq", {7'd0, irq}, 8'h01);
    clearIrq();
    drivePacket = 2'b00;
    wr(1'b0, 3'd7, 8'hEC);
    check("R13 disk identify strobe", {4'd0, strbSeen}, 8'h02);
    rd(1'b0, 3'd1, v); check("R13 disk identify no error", v, 8'h00);
    clearIrq();
  endtask

  task automatic t_features();
    logic [7:0] v;
    wr(1'b0, 3'd1, 8'h03); wr(1'b0, 3'd7, 8'hEF);
    check("R8 good feature irq", {7'd0, irq}, 8'h01);
    rd(1'b0, 3'd1, v); check("R8 good feature no error", v, 8'h00);
    clearIrq();
    wr(1'b0, 3'd1, 8'h55); wr(1'b0, 3'd7, 8'hEF);
    check("R8 bad feature irq", {7'd0, irq}, 8'h01);
    clearIrq();
    wr(1'b0, 3'd7, 8'h10);           // R10: clears previous abort
    rd(1'b0, 3'd1, v); check("R10 command clears error", v, 8'h00);
    check("R13 recal irq", {7'd0, irq}, 8'h01);
    clearIrq();
  endtask

  task automatic t_silent();
    logic [7:0] v;
    wr(1'b0, 3'd7, 8'hF3);
    check("R9 security no irq", {7'd0, irq}, 8'h00);
    rd(1'b0, 3'd1, v); check("R9 security abort", v, 8'h04);
    wr(1'b0, 3'd7, 8'h77);
    check("R9 unlisted no irq", {7'd0, irq}, 8'h00);
    rd(1'b0, 3'd1, v); check("R9 unlisted abort", v, 8'h04);
    wr(1'b0, 3'd7, 8'h90);
    check("R13 diagnose irq", {7'd0, irq}, 8'h01);
    rd(1'b0, 3'd1, v); check("R13 diagnose code", v, 8'h01);
    clearIrq();
    wr(1'b0, 3'd7, 8'hA0);
    check("R13 packet strobe", {4'd0, strbSeen}, 8'h01);
    check("R13 packet no irq", {7'd0, irq}, 8'h00);
    check("R13 cmdCode", cmdCode, 8'hA0);
  endtask

  task automatic t_readwrite();
    logic [7:0] v;
    wr(1'b0, 3'd7, 8'h20);
    check("R11 read strobe", {4'd0, strbSeen}, 8'h08);
    check("R11 read no immediate irq", {7'd0, irq}, 8'h00);
    wr(1'b0, 3'd7, 8'hC5);
    check("R11 write multi strobe", {4'd0, strbSeen}, 8'h04);
    @(negedge clk); cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 done holds irq", {7'd0, irq}, 8'h01);
    rd(1'b1, 3'd0, v);
    check("R4 alt read leaves irq", {7'd0, irq}, 8'h01);
    rd(1'b0, 3'd7, v);
    check("R11 status read drops irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_softreset();
    logic [7:0] v;
    drivePacket = 2'b01;
    wr(1'b0, 3'd4, 8'h33); wr(1'b0, 3'd5, 8'h44);
    wr(1'b1, 3'd0, 8'h04);
    rd(1'b0, 3'd4, v); check("R6 signature lo", v, 8'h14);
    rd(1'b0, 3'd5, v); check("R6 signature hi", v, 8'hEB);
    drivePresent = 2'b11;
    wr(1'b0, 3'd6, 8'hB0);            // drive1 not packet
    rd(1'b0, 3'd4, v); check("R6 non-packet stored lo", v, 8'h33);
    wr(1'b0, 3'd6, 8'hA0);
    wr(1'b0, 3'd7, 8'h10);            // leaves reset state
    rd(1'b0, 3'd5, v); check("R6 after command stored hi", v, 8'h44);
    clearIrq();
    drivePresent = 2'b01; drivePacket = 2'b00;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_regs();
    t_status();
    t_data();
    t_absent();
    t_identify();
    t_features();
    t_silent();
    t_readwrite();
    t_softreset();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule